// File: doc/BRIEF.md
# Stepped DAC Sample Buffer with Pointer Status

This block keeps a small table of 12-bit conversion codes for a digital-to-analog converter and presents one of them at a time on its data output. A read pointer chooses the entry on show. Each accepted trigger moves the pointer forward by one. When a trigger arrives while the pointer already equals the programmed upper limit, the pointer returns to entry 0. The trigger comes either from a hardware input pin or from a software strobe bit in a control register, and a control bit selects which of the two is used.

As the pointer moves, three sticky flags record where it has been. One flag records the start of the table (entry 0). One records the upper limit. One records a watermark, which is a programmable number of entries below the limit. An interrupt line goes high when any flag is set and the enable for that flag is also set. Software uses a word-wide register port to fill the table, set the pointer and the limit, pick the trigger source and the watermark distance, and clear flags.

Register map. Address bit 4 set selects table entry `addr[3:0]`. Otherwise: address 0 is control A, address 1 is control B, address 2 holds the pointer and limit, and address 3 is status.

Top module: `dac_stepbuf`

## Requirements
- R1: After reset the pointer is 0, the limit is 15, and status reads 0x2, because the start flag is already set. Both control registers read 0, `irq` is low, and every table entry is 0.
- R2: Each accepted trigger moves the pointer from p to p+1. When p equals the limit, the trigger moves the pointer to 0 instead.
- R3: The pointer/limit register (address 2) holds the pointer in bits [7:4] and the limit in bits [3:0]. Both fields can be written and read back. A write there does not change status.
- R4: Status bit 0 (limit flag) sets on the step whose new pointer equals the limit.
- R5: Status bit 1 (start flag) sets on the step whose new pointer is 0.
- R6: Status bit 2 (watermark flag) sets on the step whose new pointer equals limit − (W+1). W is control B bits [2:1]. The flag never sets when the limit is below W+1.
- R7: A flag stays set until status is written. A status write clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1.
- R8: If a flag-set event and a status write that clears the same flag fall in the same cycle, the flag ends up set.
- R9: Control A bit 5 set selects the software trigger. In that mode, a write to control A with bit 4 set steps the pointer once and `hwTrig` is ignored. With bit 5 clear, each cycle in which `hwTrig` is high is one trigger, and bit 4 has no effect. Bit 4 always reads 0.
- R10: `irq` is high exactly when some status flag is set and its enable is set. The enables are control A bit 0 (limit), bit 1 (start) and bit 2 (watermark).
- R11: While control B bit 0 (buffer enable) is 0, triggers do not move the pointer and `dacOut` shows entry 0.
- R12: Writing address 16+i stores entry i, and reading address 16+i returns it. While the buffer is enabled, `dacOut` shows the entry at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register or table address |
| regWr | input | 1 | Write strobe for the register port |
| regWrData | input | 12 | Write data |
| regRdData | output | 12 | Read data for `regAddr` (combinational) |
| hwTrig | input | 1 | Hardware step request, one trigger per high cycle |
| irq | output | 1 | Interrupt request |
| dacOut | output | 12 | Code sent to the converter |

## Verification
The bench builds the block with its default parameters: 12-bit entries and a 4-bit pointer. Every pointer value from 0 to 15 can therefore be reached in a few triggers, and the register layout from the requirements applies as written. A limit of 8 with a watermark distance of 4 runs the pointer through several complete wraps, so the start, watermark and limit flags each fire at known pointer values. A limit of 2 against the same distance covers the case where the watermark position falls below entry 0. A trigger placed in the same cycle as a status clear covers the collision rule.

// File: rtl/dac_stepbuf_pkg.sv
package dac_stepbuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;      // advance the read pointer
    logic ptrLimWr;  // load pointer and limit from write data
    logic entryWr;   // store write data in a table entry
  } dpStrobe_t;

  // Pointer arrival events, datapath to control
  typedef struct packed {
    logic atStart;
    logic atLimit;
    logic atWater;
  } dpEvent_t;

  localparam int NFLAGS     = 3;
  localparam int FLAG_LIMIT = 0;
  localparam int FLAG_START = 1;
  localparam int FLAG_WATER = 2;

  // Pointer rests at entry 0 after reset, so the start flag begins set
  localparam logic [NFLAGS-1:0] STATUS_RST = 3'b010;

endpackage

// File: rtl/dac_stepbuf_data.sv
module dac_stepbuf_data
  import dac_stepbuf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PTR_W  = 4,
  parameter int WM_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bufEn,
  input  logic [WM_W-1:0]   wmSel,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [PTR_W-1:0]  ptrQ,
  output logic [PTR_W-1:0]  limQ,
  output dpEvent_t          evt,
  output logic [DATA_W-1:0] dacOut,
  output logic [DATA_W-1:0] rdEntry
);

  localparam int DEPTH  = 1 << PTR_W;
  localparam int DIST_W = PTR_W + 1;

  logic [DATA_W-1:0] entry [DEPTH];
  logic [PTR_W-1:0]  nxtPtr;
  logic [DIST_W-1:0] wmDist;
  logic              waterReach;
  logic [PTR_W-1:0]  waterPos;

  // Sample table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else if (stb.entryWr) begin
      entry[wrIdx] <= wrData;
    end
  end

  // Pointer stepping with wrap at the limit
  always_comb begin
    nxtPtr = (ptrQ == limQ) ? '0 : ptrQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      limQ <= '1;
    end else if (stb.ptrLimWr) begin
      ptrQ <= wrData[2*PTR_W-1:PTR_W];
      limQ <= wrData[PTR_W-1:0];
    end else if (stb.step) begin
      ptrQ <= nxtPtr;
    end
  end

  // Watermark position: limit minus (setting + 1), only if non-negative
  always_comb begin
    wmDist     = DIST_W'(wmSel) + 1'b1;
    waterReach = ({1'b0, limQ} >= wmDist);
    waterPos   = limQ - wmDist[PTR_W-1:0];
  end

  always_comb begin
    evt.atStart = stb.step && (nxtPtr == '0);
    evt.atLimit = stb.step && (nxtPtr == limQ);
    evt.atWater = stb.step && waterReach && (nxtPtr == waterPos);
  end

  // Converter code and register readback
  always_comb begin
    dacOut  = bufEn ? entry[ptrQ] : entry[0];
    rdEntry = entry[rdIdx];
  end

endmodule

// File: rtl/dac_stepbuf_ctrl.sv
module dac_stepbuf_ctrl
  import dac_stepbuf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PTR_W  = 4,
  parameter int WM_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PTR_W:0]    regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              hwTrig,
  input  dpEvent_t          evt,
  input  logic [PTR_W-1:0]  ptrQ,
  input  logic [PTR_W-1:0]  limQ,
  input  logic [DATA_W-1:0] rdEntry,
  output dpStrobe_t         stb,
  output logic              bufEn,
  output logic [WM_W-1:0]   wmSel,
  output logic [NFLAGS-1:0] statusQ,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  localparam int ADDR_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRLA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRLB  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PTRLIM = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(3);
  localparam int CA_SWSTEP = 4;
  localparam int CA_SWSEL  = 5;
  localparam int CB_BUFEN  = 0;
  localparam int CB_WM_LSB = 1;

  logic [NFLAGS-1:0] irqEnQ;
  logic              swSelQ;
  logic              bufEnQ;
  logic [WM_W-1:0]   wmSelQ;
  logic              inTable;
  logic              wrCtrlA, wrCtrlB, wrPtrLim, wrStatus;
  logic              swStep, trigger;
  logic [NFLAGS-1:0] setMask, clrMask;
  logic              unusedWrBits;

  // Address decode
  always_comb begin
    inTable  = regAddr[PTR_W];
    wrCtrlA  = regWr && (regAddr == A_CTRLA);
    wrCtrlB  = regWr && (regAddr == A_CTRLB);
    wrPtrLim = regWr && (regAddr == A_PTRLIM);
    wrStatus = regWr && (regAddr == A_STATUS);
  end

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= '0;
      swSelQ <= 1'b0;
    end else if (wrCtrlA) begin
      irqEnQ <= regWrData[NFLAGS-1:0];
      swSelQ <= regWrData[CA_SWSEL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufEnQ <= 1'b0;
      wmSelQ <= '0;
    end else if (wrCtrlB) begin
      bufEnQ <= regWrData[CB_BUFEN];
      wmSelQ <= regWrData[CB_WM_LSB +: WM_W];
    end
  end

  // Trigger source selection; a pointer load takes precedence over a step
  always_comb begin
    swStep       = wrCtrlA && swSelQ && regWrData[CA_SWSTEP];
    trigger      = swSelQ ? swStep : hwTrig;
    stb.ptrLimWr = wrPtrLim;
    stb.entryWr  = regWr && inTable;
    stb.step     = bufEnQ && trigger && !wrPtrLim;
  end

  // Sticky flags: write-zero clears, a same-cycle set wins
  always_comb begin
    setMask             = '0;
    setMask[FLAG_LIMIT] = evt.atLimit;
    setMask[FLAG_START] = evt.atStart;
    setMask[FLAG_WATER] = evt.atWater;
    clrMask             = wrStatus ? ~regWrData[NFLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= STATUS_RST;
    else       statusQ <= (statusQ & ~clrMask) | setMask;
  end

  // Readback
  always_comb begin
    regRdData = '0;
    if (inTable) begin
      regRdData = rdEntry;
    end else begin
      case (regAddr)
        A_CTRLA: begin
          regRdData[NFLAGS-1:0] = irqEnQ;
          regRdData[CA_SWSEL]   = swSelQ;
        end
        A_CTRLB: begin
          regRdData[CB_BUFEN]            = bufEnQ;
          regRdData[CB_WM_LSB +: WM_W]   = wmSelQ;
        end
        A_PTRLIM: regRdData[2*PTR_W-1:0] = {ptrQ, limQ};
        A_STATUS: regRdData[NFLAGS-1:0]  = statusQ;
        default:  regRdData = '0;
      endcase
    end
  end

  always_comb begin
    irq   = |(statusQ & irqEnQ);
    bufEn = bufEnQ;
    wmSel = wmSelQ;
  end

  assign unusedWrBits = ^{regWrData[DATA_W-1:CA_SWSEL+1], regWrData[3]};

endmodule

// File: rtl/dac_stepbuf.sv
module dac_stepbuf
  import dac_stepbuf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PTR_W  = 4,
  parameter int WM_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PTR_W:0]    regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              hwTrig,
  output logic              irq,
  output logic [DATA_W-1:0] dacOut
);

  dpStrobe_t         stb;
  dpEvent_t          evt;
  logic              bufEn;
  logic [WM_W-1:0]   wmSel;
  logic [PTR_W-1:0]  ptrQ;
  logic [PTR_W-1:0]  limQ;
  logic [DATA_W-1:0] rdEntry;
  logic [NFLAGS-1:0] statusQ;

  dac_stepbuf_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W), .WM_W(WM_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .hwTrig    (hwTrig),
    .evt       (evt),
    .ptrQ      (ptrQ),
    .limQ      (limQ),
    .rdEntry   (rdEntry),
    .stb       (stb),
    .bufEn     (bufEn),
    .wmSel     (wmSel),
    .statusQ   (statusQ),
    .regRdData (regRdData),
    .irq       (irq)
  );

  dac_stepbuf_data #(.DATA_W(DATA_W), .PTR_W(PTR_W), .WM_W(WM_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrIdx   (regAddr[PTR_W-1:0]),
    .wrData  (regWrData),
    .bufEn   (bufEn),
    .wmSel   (wmSel),
    .rdIdx   (regAddr[PTR_W-1:0]),
    .ptrQ    (ptrQ),
    .limQ    (limQ),
    .evt     (evt),
    .dacOut  (dacOut),
    .rdEntry (rdEntry)
  );

endmodule

// File: rtl/dac_stepbuf_chk.sv
module dac_stepbuf_chk
  import dac_stepbuf_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [PTR_W:0]    regAddr,
  input logic              regWr,
  input logic              step,
  input logic              ptrLimWr,
  input logic              bufEn,
  input logic [PTR_W-1:0]  ptr,
  input logic [PTR_W-1:0]  lim,
  input logic [NFLAGS-1:0] status
);

  logic statusWr;
  logic [PTR_W-1:0] ptrInc;
  assign statusWr = regWr && (regAddr == (PTR_W+1)'(3));
  assign ptrInc   = ptr + 1'b1;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (step && ptr == lim) |=> (ptr == '0)); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (step && ptr != lim) |=> (ptr == $past(ptrInc))); // R2

  AST_START_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (step && ptr == lim) |=> status[FLAG_START]); // R5

  AST_LIMIT_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (step && ptr != lim && ptrInc == lim) |=> status[FLAG_LIMIT]); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !statusWr |=> ((status & $past(status)) == $past(status))); // R7

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEn && !ptrLimWr) |=> $stable(ptr)); // R11

endmodule

bind dac_stepbuf dac_stepbuf_chk #(.PTR_W(PTR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .step     (stb.step),
  .ptrLimWr (stb.ptrLimWr),
  .bufEn    (bufEn),
  .ptr      (ptrQ),
  .lim      (limQ),
  .status   (statusQ)
);

// File: tb/dac_stepbuf_test.sv
module dac_stepbuf_test;
  localparam int DW = 12;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [PW:0]   regAddr;
  logic          regWr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic          hwTrig;
  logic          irq;
  logic [DW-1:0] dacOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  int expPtr;
  int expLim;

  always #4 clk = ~clk;

  dac_stepbuf uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .hwTrig(hwTrig),
    .irq(irq), .dacOut(dacOut)
  );

  function automatic logic [DW-1:0] entVal(int i);
    return DW'((i * 293 + 7) % 4096);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    regAddr = (PW+1)'(addr); regWrData = DW'(data); regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(int addr, output int data);
    regAddr = (PW+1)'(addr);
    #1;
    data = int'(regRdData);
  endtask

  task automatic pulse();
    @(negedge clk); hwTrig = 1'b1;
    @(negedge clk); hwTrig = 1'b0;
    #1;
  endtask

  function automatic void modelStep();
    expPtr = (expPtr == expLim) ? 0 : expPtr + 1;
  endfunction

  task automatic checkPtr(string tag);
    int v;
    rd(2, v);
    chk(tag, (v >> 4) & 15, expPtr);
  endtask

  task automatic testReset();
    int v;
    rd(3, v); chk("R1 status after reset", v, 2);
    rd(2, v); chk("R1 ptr/limit after reset", v, 'h0F);
    rd(1, v); chk("R1 control B after reset", v, 0);
    rd(0, v); chk("R1 control A after reset", v, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 dacOut after reset", dacOut, 0);
    rd(16 + 9, v); chk("R1 entry cleared", v, 0);
  endtask

  task automatic testFill();
    int v;
    for (int i = 0; i < 16; i++) wr(16 + i, entVal(i));
    rd(16 + 5, v);  chk("R12 entry 5 readback", v, entVal(5));
    rd(16 + 15, v); chk("R12 entry 15 readback", v, entVal(15));
  endtask

  task automatic testRun();
    int v;
    wr(1, 'h007);              // enable, watermark setting 3
    wr(2, 'h008);              // ptr 0, limit 8
    rd(2, v); chk("R3 ptr/limit readback", v, 'h08);
    rd(3, v); chk("R3 status untouched by ptr write", v, 2);
    expPtr = 0; expLim = 8;
    wr(3, 0);
    for (int n = 0; n < 20; n++) begin
      pulse();
      modelStep();
      rd(2, v);
      chk("R2 pointer after step", (v >> 4) & 15, expPtr);
      chk("R3 limit field", v & 15, 8);
      rd(3, v);
      chk("R4 R5 R6 status flags", v,
          ((expPtr == 4) ? 4 : 0) | ((expPtr == 0) ? 2 : 0) | ((expPtr == 8) ? 1 : 0));
      chk("R12 dacOut at pointer", dacOut, entVal(expPtr));
      wr(3, 0);
    end
  endtask

  task automatic testSticky();
    int v;
    // pointer is at 2 here
    pulse(); modelStep(); pulse(); modelStep();
    for (int n = 0; n < 3; n++) begin pulse(); modelStep(); end
    rd(3, v); chk("R7 watermark stays set", v, 4);
    wr(3, 'h003);
    rd(3, v); chk("R7 write 0 clears watermark", v, 0);
    pulse(); modelStep();
    rd(3, v); chk("R4 limit flag at 8", v, 1);
    wr(3, 'h001);
    rd(3, v); chk("R7 write 1 keeps flag", v, 1);
    wr(3, 0);
    rd(3, v); chk("R7 write 0 clears limit", v, 0);
  endtask

  task automatic testIrq();
    wr(0, 'h007);
    #1; chk("R10 irq low with no flags", irq, 0);
    pulse(); modelStep();
    chk("R10 irq on start flag", irq, 1);
    wr(0, 'h001);
    #1; chk("R10 irq masked by enable", irq, 0);
    wr(0, 'h002);
    #1; chk("R10 irq with start enable", irq, 1);
    wr(3, 0);
    #1; chk("R10 irq drops after clear", irq, 0);
    wr(0, 0);
  endtask

  task automatic testSwTrig();
    int v;
    wr(0, 'h020);
    pulse();
    checkPtr("R9 hwTrig ignored in software mode");
    wr(0, 'h030); modelStep();
    checkPtr("R9 software step");
    rd(0, v); chk("R9 step bit reads 0", v, 'h020);
    wr(0, 'h000);
    wr(0, 'h010);
    checkPtr("R9 step bit ignored in hardware mode");
    wr(0, 0);
  endtask

  task automatic testSetWins();
    int v;
    wr(2, 'h078); expPtr = 7;
    wr(3, 0);
    @(negedge clk);
    hwTrig = 1'b1; regAddr = 5'd3; regWrData = '0; regWr = 1'b1;
    @(negedge clk);
    hwTrig = 1'b0; regWr = 1'b0;
    modelStep();
    rd(3, v); chk("R8 set beats clear", v, 1);
    checkPtr("R8 pointer reached limit");
    wr(3, 0);
  endtask

  task automatic testDisable();
    int v;
    wr(2, 'h038); expPtr = 3;
    wr(1, 'h006);
    #1; chk("R11 dacOut shows entry 0", dacOut, entVal(0));
    pulse();
    checkPtr("R11 pointer held while disabled");
    rd(3, v); chk("R11 no flags while disabled", v, 0);
    wr(1, 'h007);
    #1; chk("R12 dacOut follows pointer again", dacOut, entVal(3));
  endtask

  task automatic testWaterRange();
    int v;
    wr(2, 'h002); expPtr = 0; expLim = 2;
    wr(3, 0);
    for (int n = 0; n < 6; n++) begin pulse(); modelStep(); end
    rd(3, v); chk("R6 no watermark when limit below distance", v, 3);
    checkPtr("R2 wrap with limit 2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWr = 1'b0; regWrData = '0; hwTrig = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFill();
    testRun();
    testSticky();
    testIrq();
    testSwTrig();
    testSetWins();
    testDisable();
    testWaterRange();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule